// File: doc/BRIEF.md
# Four-Phase Fetch-Execute Sequencer

This block paces a small single-accumulator controller core. It divides the system clock into four non-overlapping phases, T1 to T4, that make up one instruction cycle. During each instruction cycle the core executes the word held in the instruction register while the word at the program counter is fetched. At the end of T4 the fetched word moves into the instruction register and the 12-bit program counter advances by one. A flow change replaces that word with a no-operation and loads a new address instead. The block also brings out a square wave at one quarter of the system clock.

Control requests come from an external decoder. These requests are jump, taken skip, write of the counter's low byte, call, return and interrupt. They are sampled once per instruction cycle, at the end of T4. Calls and interrupts save the fetch address on an eight-level hardware return stack, and returns restore it. The ALU, the decoder and the program memory sit outside the block. The memory is read combinationally at `pc_o` and its word is presented on `instr_i`.

Top module: `fetch_seq`

## Requirements
- R1: `phase_o` is one-hot: bit 0 is T1, bit 1 is T2, bit 2 is T3 and bit 3 is T4. It advances T1, T2, T3, T4, T1 on every clock.
- R2: `clk_div4_o` is high during T1 and T2 and low during T3 and T4, which gives one quarter of the clock rate.
- R3: While `rst_ni` is low, `pc_o` is 0, `ir_o` is the no-operation word (all zeros), the phase is T1 and the return stack is empty.
- R4: `pc_o` and `ir_o` change only on the clock edge that ends T4. A request that is present on any other edge has no effect.
- R5: With no request at the end of T4, `ir_o` takes `instr_i` (the word at `pc_o`) and `pc_o` becomes `pc_o`+1, wrapping from 0xFFF to 0.
- R6: Any accepted request loads `ir_o` with the no-operation word. When several requests are present together, the one accepted is chosen in this order: call, return, jump, low-byte write, skip, interrupt.
- R7: A jump loads `pc_o` with `jump_addr_i`.
- R8: A taken skip discards the fetched word and sets `pc_o` to `pc_o`+1.
- R9: A low-byte write replaces `pc_o[7:0]` with `pcl_data_i` and keeps `pc_o[11:8]`.
- R10: A call pushes the current `pc_o` and loads `jump_addr_i`. A return loads the most recently pushed address and removes it.
- R11: An interrupt pushes the current `pc_o` and loads the vector 4 + 4*`int_sel_i` (4 for source 0, 8 for source 1).
- R12: The stack holds 8 addresses. A push onto a full stack drops the oldest entry. A return on an empty stack loads an unspecified address, does not fault, and leaves the stack empty, so later calls and returns pair up correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_i | input | 16 | Program memory word at `pc_o` |
| jump_i | input | 1 | Jump request |
| jump_addr_i | input | 12 | Target for jump and call |
| skip_i | input | 1 | Taken-skip request |
| pcl_wr_i | input | 1 | Low-byte write request |
| pcl_data_i | input | 8 | New low byte of the counter |
| call_i | input | 1 | Call request |
| ret_i | input | 1 | Return request |
| int_i | input | 1 | Interrupt request |
| int_sel_i | input | 1 | Interrupt source select |
| pc_o | output | 12 | Program memory address |
| ir_o | output | 16 | Instruction register |
| phase_o | output | 4 | One-hot phase T1..T4 |
| clk_div4_o | output | 1 | Clock divided by four |

## Verification
The bench uses the default parameters: a 12-bit counter, a stack depth of 8, 16-bit words and two interrupt sources. With a 12-bit counter, a jump near 0xFFF lets the wrap to zero be observed, and a low-byte write from a nonzero upper nibble shows that the upper bits are kept. With a depth of 8, nine nested calls followed by nine returns reach the overflow case and then the empty-pop case. Simultaneous requests check the priority order, and one-clock pulses outside T4 check that requests are ignored there.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [1:0] {PH_T1, PH_T2, PH_T3, PH_T4} phase_e;
  typedef enum logic [2:0] {FL_SEQ, FL_CALL, FL_RET, FL_JUMP, FL_PCL, FL_SKIP, FL_INT} flow_e;
endpackage

// File: rtl/phase_gen.sv
module phase_gen
  import seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  output phase_e     ph_o,
  output logic [3:0] phase_oh_o,
  output logic       clk_div4_o
);
  phase_e ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= PH_T1;
    else         ph_q <= phase_e'(ph_q + 2'd1);
  end

  assign ph_o = ph_q;

  always_comb begin
    phase_oh_o = '0;
    phase_oh_o[ph_q] = 1'b1;
  end

  assign clk_div4_o = (ph_q == PH_T1) || (ph_q == PH_T2);

  a_r1_phase_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(phase_oh_o) == 1);
  a_r1_t4_then_t1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_oh_o[3] |=> phase_oh_o[0]);
  a_r2_div_rise_at_t1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clk_div4_o) |-> phase_oh_o[0]);
endmodule

// File: rtl/ret_stack.sv
module ret_stack #(
  parameter int DEPTH = 8,
  parameter int W     = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] dout_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q;
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] top_idx;

  assign top_idx = (wp_q == '0) ? AW'(DEPTH - 1) : wp_q - 1'b1;
  assign dout_o  = mem_q[top_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (push_i) begin
      mem_q[wp_q] <= din_i;  // overwrites oldest when full
      wp_q        <= (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      if (cnt_q != CW'(DEPTH)) cnt_q <= cnt_q + 1'b1;
    end else if (pop_i && cnt_q != '0) begin
      wp_q  <= top_idx;
      cnt_q <= cnt_q - 1'b1;
    end
  end

  a_r12_depth_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  a_r12_empty_pop_stays: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && cnt_q == '0) |=> cnt_q == '0);
  a_r12_push_full_stays: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && cnt_q == CW'(DEPTH)) |=> cnt_q == CW'(DEPTH));
endmodule

// File: rtl/fetch_seq.sv
module fetch_seq
  import seq_pkg::*;
#(
  parameter int PC_W      = 12,
  parameter int IW        = 16,
  parameter int PCL_W     = 8,
  parameter int DEPTH     = 8,
  parameter int NUM_INT   = 2,
  parameter int INT_BASE  = 4,
  parameter int INT_STEP  = 4,
  parameter logic [IW-1:0] NOP_WORD = '0,
  localparam int ISW = (NUM_INT > 1) ? $clog2(NUM_INT) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IW-1:0]    instr_i,
  input  logic             jump_i,
  input  logic [PC_W-1:0]  jump_addr_i,
  input  logic             skip_i,
  input  logic             pcl_wr_i,
  input  logic [PCL_W-1:0] pcl_data_i,
  input  logic             call_i,
  input  logic             ret_i,
  input  logic             int_i,
  input  logic [ISW-1:0]   int_sel_i,
  output logic [PC_W-1:0]  pc_o,
  output logic [IW-1:0]    ir_o,
  output logic [3:0]       phase_o,
  output logic             clk_div4_o
);
  phase_e         ph;
  flow_e          flow;
  logic           cyc_end;
  logic [PC_W-1:0] pc_q, pc_nx, stk_top, vec_addr;
  logic [IW-1:0]  ir_q;

  phase_gen u_phase (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ph_o       (ph),
    .phase_oh_o (phase_o),
    .clk_div4_o (clk_div4_o)
  );

  assign cyc_end = (ph == PH_T4);

  always_comb begin
    if      (call_i)   flow = FL_CALL;
    else if (ret_i)    flow = FL_RET;
    else if (jump_i)   flow = FL_JUMP;
    else if (pcl_wr_i) flow = FL_PCL;
    else if (skip_i)   flow = FL_SKIP;
    else if (int_i)    flow = FL_INT;
    else               flow = FL_SEQ;
  end

  assign vec_addr = PC_W'(INT_BASE) + PC_W'(int_sel_i) * PC_W'(INT_STEP);

  ret_stack #(.DEPTH(DEPTH), .W(PC_W)) u_stack (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (cyc_end && (flow == FL_CALL || flow == FL_INT)),
    .pop_i  (cyc_end && flow == FL_RET),
    .din_i  (pc_q),
    .dout_o (stk_top)
  );

  always_comb begin
    unique case (flow)
      FL_CALL, FL_JUMP: pc_nx = jump_addr_i;
      FL_RET:           pc_nx = stk_top;
      FL_PCL:           pc_nx = {pc_q[PC_W-1:PCL_W], pcl_data_i};
      FL_INT:           pc_nx = vec_addr;
      default:          pc_nx = pc_q + 1'b1;  // sequential and skip
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= '0;
      ir_q <= NOP_WORD;
    end else if (cyc_end) begin
      pc_q <= pc_nx;
      ir_q <= (flow == FL_SEQ) ? instr_i : NOP_WORD;
    end
  end

  assign pc_o = pc_q;
  assign ir_o = ir_q;

  a_r4_pc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !phase_o[3] |=> $stable(pc_o) && $stable(ir_o));
  a_r5_seq_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o[3] && !(call_i || ret_i || jump_i || pcl_wr_i || skip_i || int_i))
      |=> pc_o == $past(pc_o) + 1'b1);
  a_r6_flush_nop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o[3] && (call_i || ret_i || jump_i || pcl_wr_i || skip_i || int_i))
      |=> ir_o == NOP_WORD);
  a_r9_high_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o[3] && pcl_wr_i && !call_i && !ret_i && !jump_i)
      |=> pc_o[PC_W-1:PCL_W] == $past(pc_o[PC_W-1:PCL_W]));
endmodule

// File: tb/fetch_seq_test.sv
module fetch_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] instr;
  logic        jump = 0, skip = 0, pcl_wr = 0, call = 0, ret = 0, irq = 0;
  logic [11:0] jaddr = '0;
  logic [7:0]  pcl_data = '0;
  logic [0:0]  irq_sel = '0;
  logic [11:0] pc;
  logic [15:0] ir;
  logic [3:0]  phase;
  logic        div4;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #2 clk = ~clk;  // 250 MHz

  function automatic logic [15:0] rom(input logic [11:0] a);
    return {4'hA, a};
  endfunction

  assign instr = rom(pc);

  fetch_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .instr_i(instr),
    .jump_i(jump), .jump_addr_i(jaddr), .skip_i(skip),
    .pcl_wr_i(pcl_wr), .pcl_data_i(pcl_data), .call_i(call),
    .ret_i(ret), .int_i(irq), .int_sel_i(irq_sel),
    .pc_o(pc), .ir_o(ir), .phase_o(phase), .clk_div4_o(div4)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // behavioural reference model
  int          m_ph = 0;
  logic [11:0] m_pc = '0;
  logic [15:0] m_ir = '0;
  logic [11:0] m_stk[$];
  bit          m_unk = 0;
  string       pc_tag = "R3", ir_tag = "R3";

  always @(clk) begin
    if (clk) begin
      if (!rst_n) begin
        m_ph = 0; m_pc = '0; m_ir = '0; m_stk.delete();
        pc_tag = "R3"; ir_tag = "R3";
      end else begin
        if (m_ph == 3) begin
          ir_tag = "R6";
          if (call) begin
            m_stk.push_back(m_pc);
            pc_tag = (m_stk.size() > 8) ? "R12" : "R10";
            if (m_stk.size() > 8) void'(m_stk.pop_front());
            m_pc = jaddr; m_ir = '0;
          end else if (ret) begin
            if (m_stk.size() == 0) begin m_unk = 1; pc_tag = "R12"; end
            else begin m_pc = m_stk.pop_back(); pc_tag = "R10"; end
            m_ir = '0;
          end else if (jump) begin
            m_pc = jaddr; m_ir = '0; pc_tag = "R7";
          end else if (pcl_wr) begin
            m_pc = {m_pc[11:8], pcl_data}; m_ir = '0; pc_tag = "R9";
          end else if (skip) begin
            m_pc = m_pc + 1; m_ir = '0; pc_tag = "R8";
          end else if (irq) begin
            m_stk.push_back(m_pc);
            if (m_stk.size() > 8) void'(m_stk.pop_front());
            m_pc = 12'(4 + 4 * irq_sel); m_ir = '0; pc_tag = "R11";
          end else begin
            m_ir = rom(m_pc); m_pc = m_pc + 1; pc_tag = "R5"; ir_tag = "R5";
          end
        end else begin
          pc_tag = "R4"; ir_tag = "R4";
        end
        m_ph = (m_ph + 1) % 4;
      end
    end else begin
      if (m_unk) begin m_pc = pc; m_unk = 0; end  // empty pop: value unspecified
      chk("R1", "phase_o", phase, 1 << m_ph);
      chk("R2", "clk_div4_o", div4, (m_ph < 2) ? 1 : 0);
      chk(pc_tag, "pc_o", pc, m_pc);
      chk(ir_tag, "ir_o", ir, m_ir);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_reqs;
    jump = 0; skip = 0; pcl_wr = 0; call = 0; ret = 0; irq = 0;
  endtask

  // hold a request for exactly one instruction cycle (one T4 edge)
  task automatic hold_cycle;
    idle(4);
    clear_reqs();
  endtask

  task automatic do_jump(input logic [11:0] a);
    @(negedge clk); jaddr = a; jump = 1; hold_cycle();
  endtask

  task automatic do_call(input logic [11:0] a);
    @(negedge clk); jaddr = a; call = 1; hold_cycle();
  endtask

  task automatic do_ret;
    @(negedge clk); ret = 1; hold_cycle();
  endtask

  initial begin
    int k;
    idle(3);
    chk("R3", "pc_o in reset", pc, 0);
    chk("R3", "ir_o in reset", ir, 0);
    chk("R3", "phase_o in reset", phase, 1);
    rst_n = 1;
    idle(24);                                   // R5 sequential fetch
    do_jump(12'h123); idle(12);                 // R7
    @(negedge clk); skip = 1; hold_cycle(); idle(8);          // R8
    @(negedge clk); pcl_data = 8'h45; pcl_wr = 1; hold_cycle(); idle(8); // R9
    do_call(12'h300); idle(8);                  // R10
    do_call(12'h400); idle(8);
    do_ret(); idle(8);
    do_ret(); idle(8);
    @(negedge clk); irq_sel = 0; irq = 1; hold_cycle(); idle(8); // R11
    @(negedge clk); irq_sel = 1; irq = 1; hold_cycle(); idle(8);
    do_ret(); do_ret(); idle(8);
    // R6 priority: call beats jump and interrupt, jump beats skip
    @(negedge clk); jaddr = 12'h555; call = 1; jump = 1; irq = 1; hold_cycle(); idle(4);
    @(negedge clk); jaddr = 12'h666; jump = 1; skip = 1; pcl_wr = 1; hold_cycle(); idle(4);
    @(negedge clk); ret = 1; jump = 1; hold_cycle(); idle(4);
    @(negedge clk); pcl_data = 8'h10; pcl_wr = 1; skip = 1; irq = 1; hold_cycle(); idle(4);
    @(negedge clk); skip = 1; irq = 1; hold_cycle(); idle(4);
    do_ret(); idle(4);
    // R4: one-clock pulses on non-T4 edges are ignored
    for (int p = 0; p < 3; p++) begin
      while (phase != (4'b0001 << p)) @(negedge clk);
      jaddr = 12'h777; jump = 1; call = 1;
      @(negedge clk); clear_reqs();
      idle(6);
    end
    // R5 wrap from 0xFFF
    do_jump(12'hFFE); idle(16);
    // R12 overflow then empty pop
    for (int i = 0; i < 9; i++) do_call(12'h800 + 12'(16 * i));
    for (int i = 0; i < 9; i++) begin do_ret(); idle(4); end
    do_ret(); idle(4);
    do_call(12'h9A0); idle(4); do_ret(); idle(8);
    k = checks;
    $display("TB_RESULT checks=%0d failures=%0d", k, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule